// File: doc/BRIEF.md
# Screen Tile Triangle Binner

This block sorts screen-space triangles into 32x32-pixel screen tiles for a sort-middle renderer. Each triangle arrives as three vertices with signed integer pixel coordinates and an identifier, over a valid/ready handshake. The block finds the axis-aligned bounding box of the three vertices and clamps it to the screen. It then walks every tile the clamped box touches and emits one bin record per tile. A record carries the linear tile index, the triangle identifier and a flag that marks the triangle's final record.

Coverage is conservative: any tile inside the clamped box receives the triangle, even if the triangle's edges miss that tile. The records leave over a second valid/ready handshake that can stall at any cycle. A new triangle is taken only after the previous one has produced all of its records. Downstream storage collects the records, so each tile can later be rendered on its own and in parallel with the others.

Top module: `tri_tile_binner`

## Requirements
- R1: After reset, and whenever reset is asserted, out_valid is 0 and in_ready is 1.
- R2: A triangle is accepted on a clock edge where in_valid and in_ready are both 1. in_ready is 0 in every cycle in which out_valid is 1.
- R3: Vertex coordinates are two's complement. The bounding box spans the minimum and maximum of the three x values and of the three y values. The tile column of a coordinate is x shifted right by 5 bits, and the tile row is y shifted right by 5 bits.
- R4: Before tiles are derived, the box is clamped to columns 0..SCR_W-1 and rows 0..SCR_H-1.
- R5: Records are emitted in row-major order. Within a row, columns run from the lowest to the highest tile column of the box. After the highest column, the walk moves down one tile row and restarts at the lowest column.
- R6: out_tile equals row*TILES_X+col, where TILES_X = ceil(SCR_W/32). With the default 640x480 screen, TILES_X is 20 and there are 300 tiles.
- R7: out_last is 1 only on the final record of a triangle. The cycle after that record is taken, out_valid is 0 and in_ready is 1.
- R8: A triangle whose box lies wholly outside the screen is accepted and produces no record. in_ready stays 1 in the following cycle.
- R9: While out_valid is 1 and out_ready is 0, out_tile, out_id and out_last hold their values, and the record is neither dropped nor repeated.
- R10: Every record of a triangle carries the identifier presented with that triangle.
- R11: The first record of an accepted on-screen triangle appears on the outputs in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Triangle present on the vertex inputs |
| in_ready | output | 1 | Block can take a triangle |
| in_x0 | input | COORD_W | Vertex 0 x, signed |
| in_y0 | input | COORD_W | Vertex 0 y, signed |
| in_x1 | input | COORD_W | Vertex 1 x, signed |
| in_y1 | input | COORD_W | Vertex 1 y, signed |
| in_x2 | input | COORD_W | Vertex 2 x, signed |
| in_y2 | input | COORD_W | Vertex 2 y, signed |
| in_id | input | ID_W | Triangle identifier |
| out_valid | output | 1 | Bin record present |
| out_ready | input | 1 | Consumer takes the record |
| out_tile | output | IDX_W | Linear tile index |
| out_id | output | ID_W | Identifier of the binned triangle |
| out_last | output | 1 | Final record of this triangle |

## Verification
Output backpressure can coincide with the tile walk's row wrap, where the column returns to the box's left edge and the index jumps by a full row. It can also coincide with the final record, where the walk ends and the input side reopens. The bench provokes both by replaying multi-row triangles with out_ready toggled every cycle, starting from a stalled cycle. Every held record is judged against the expected record of the row-major sequence computed in the bench, so a skipped, repeated or early-advanced tile shows up as a mismatch. It also checks that in_ready reopens only after the last record has been taken.

// File: rtl/binner_pkg.sv
package binner_pkg;

    localparam int TILE_LOG2 = 5;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/binner_bbox.sv
module binner_bbox #(
    parameter int SCR_W   = 640,
    parameter int SCR_H   = 480,
    parameter int COORD_W = 12,
    parameter int CW      = 5,
    parameter int RW      = 4
) (
    input  logic signed [COORD_W-1:0] x0,
    input  logic signed [COORD_W-1:0] y0,
    input  logic signed [COORD_W-1:0] x1,
    input  logic signed [COORD_W-1:0] y1,
    input  logic signed [COORD_W-1:0] x2,
    input  logic signed [COORD_W-1:0] y2,
    output logic                      off_screen,
    output logic [CW-1:0]             col_lo,
    output logic [CW-1:0]             col_hi,
    output logic [RW-1:0]             row_lo,
    output logic [RW-1:0]             row_hi
);
    import binner_pkg::*;

    localparam logic signed [COORD_W-1:0] XLIM = COORD_W'(SCR_W - 1);
    localparam logic signed [COORD_W-1:0] YLIM = COORD_W'(SCR_H - 1);
    localparam logic signed [COORD_W-1:0] ZERO = '0;

    function automatic logic signed [COORD_W-1:0] min3(
        input logic signed [COORD_W-1:0] a,
        input logic signed [COORD_W-1:0] b,
        input logic signed [COORD_W-1:0] c
    );
        logic signed [COORD_W-1:0] m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic logic signed [COORD_W-1:0] max3(
        input logic signed [COORD_W-1:0] a,
        input logic signed [COORD_W-1:0] b,
        input logic signed [COORD_W-1:0] c
    );
        logic signed [COORD_W-1:0] m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction

    logic signed [COORD_W-1:0] min_x, max_x, min_y, max_y;
    logic signed [COORD_W-1:0] clo_x, chi_x, clo_y, chi_y;

    always_comb begin
        min_x = min3(x0, x1, x2);
        max_x = max3(x0, x1, x2);
        min_y = min3(y0, y1, y2);
        max_y = max3(y0, y1, y2);

        off_screen = (max_x < ZERO) || (min_x > XLIM) ||
                     (max_y < ZERO) || (min_y > YLIM);

        clo_x = (min_x < ZERO) ? ZERO : min_x;
        chi_x = (max_x > XLIM) ? XLIM : max_x;
        clo_y = (min_y < ZERO) ? ZERO : min_y;
        chi_y = (max_y > YLIM) ? YLIM : max_y;

        col_lo = CW'(clo_x >>> TILE_LOG2);
        col_hi = CW'(chi_x >>> TILE_LOG2);
        row_lo = RW'(clo_y >>> TILE_LOG2);
        row_hi = RW'(chi_y >>> TILE_LOG2);
    end

endmodule

// File: rtl/binner_sweep.sv
module binner_sweep #(
    parameter int TILES_X = 20,
    parameter int CW      = 5,
    parameter int RW      = 4,
    parameter int IDX_W   = 9,
    parameter int ID_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             off_screen,
    input  logic [CW-1:0]    col_lo,
    input  logic [CW-1:0]    col_hi,
    input  logic [RW-1:0]    row_lo,
    input  logic [RW-1:0]    row_hi,
    input  logic [ID_W-1:0]  tri_id,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_tile,
    output logic [ID_W-1:0]  out_id,
    output logic             out_last
);
    import binner_pkg::*;

    typedef struct packed {
        sweep_state_e     st;
        logic [CW-1:0]    col;
        logic [CW-1:0]    clo;
        logic [CW-1:0]    chi;
        logic [RW-1:0]    row;
        logic [RW-1:0]    rhi;
        logic [IDX_W-1:0] idx;
        logic [ID_W-1:0]  id;
    } sweep_t;

    sweep_t s_q, s_d;
    logic   row_end_d, last_d;

    always_comb begin
        s_d       = s_q;
        row_end_d = (s_q.col == s_q.chi);
        last_d    = row_end_d && (s_q.row == s_q.rhi);

        unique case (s_q.st)
            ST_IDLE: begin
                if (in_valid && !off_screen) begin
                    s_d.st  = ST_SWEEP;
                    s_d.col = col_lo;
                    s_d.clo = col_lo;
                    s_d.chi = col_hi;
                    s_d.row = row_lo;
                    s_d.rhi = row_hi;
                    s_d.id  = tri_id;
                    s_d.idx = IDX_W'(int'(row_lo) * TILES_X + int'(col_lo));
                end
            end
            ST_SWEEP: begin
                if (out_ready) begin
                    if (last_d) begin
                        s_d.st = ST_IDLE;
                    end else if (row_end_d) begin
                        s_d.col = s_q.clo;
                        s_d.row = s_q.row + RW'(1);
                        s_d.idx = s_q.idx + IDX_W'(TILES_X)
                                - IDX_W'(s_q.chi - s_q.clo);
                    end else begin
                        s_d.col = s_q.col + CW'(1);
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st == ST_IDLE);
    assign out_valid = (s_q.st == ST_SWEEP);
    assign out_tile  = s_q.idx;
    assign out_id    = s_q.id;
    assign out_last  = out_valid && last_d;

endmodule

// File: rtl/tri_tile_binner.sv
module tri_tile_binner #(
    parameter int SCR_W   = 640,
    parameter int SCR_H   = 480,
    parameter int COORD_W = 12,
    parameter int ID_W    = 8,
    localparam int TILES_X = (SCR_W + 31) / 32,
    localparam int TILES_Y = (SCR_H + 31) / 32,
    localparam int NTILES  = TILES_X * TILES_Y,
    localparam int CW      = $clog2(TILES_X),
    localparam int RW      = $clog2(TILES_Y),
    localparam int IDX_W   = $clog2(NTILES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [COORD_W-1:0] in_x0,
    input  logic signed [COORD_W-1:0] in_y0,
    input  logic signed [COORD_W-1:0] in_x1,
    input  logic signed [COORD_W-1:0] in_y1,
    input  logic signed [COORD_W-1:0] in_x2,
    input  logic signed [COORD_W-1:0] in_y2,
    input  logic [ID_W-1:0]           in_id,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [IDX_W-1:0]          out_tile,
    output logic [ID_W-1:0]           out_id,
    output logic                      out_last
);

    logic          off_screen;
    logic [CW-1:0] col_lo, col_hi;
    logic [RW-1:0] row_lo, row_hi;

    binner_bbox #(
        .SCR_W  (SCR_W),
        .SCR_H  (SCR_H),
        .COORD_W(COORD_W),
        .CW     (CW),
        .RW     (RW)
    ) u_bbox (
        .x0        (in_x0),
        .y0        (in_y0),
        .x1        (in_x1),
        .y1        (in_y1),
        .x2        (in_x2),
        .y2        (in_y2),
        .off_screen(off_screen),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .row_lo    (row_lo),
        .row_hi    (row_hi)
    );

    binner_sweep #(
        .TILES_X(TILES_X),
        .CW     (CW),
        .RW     (RW),
        .IDX_W  (IDX_W),
        .ID_W   (ID_W)
    ) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .off_screen(off_screen),
        .col_lo    (col_lo),
        .col_hi    (col_hi),
        .row_lo    (row_lo),
        .row_hi    (row_hi),
        .tri_id    (in_id),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_tile  (out_tile),
        .out_id    (out_id),
        .out_last  (out_last)
    );

endmodule

// File: rtl/binner_checker.sv
module binner_checker #(
    parameter int IDX_W  = 9,
    parameter int ID_W   = 8,
    parameter int NTILES = 300
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_tile,
    input logic [ID_W-1:0]  out_id,
    input logic             out_last
);

    // R9: a stalled record is held unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_tile) && $stable(out_id) && $stable(out_last)));

    // R2: input side closed while records are pending
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R7: taking the final record ends the walk and reopens the input
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R6: index stays inside the tile grid
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_tile) < NTILES));

    // R10: identifier constant across the records of one triangle
    p_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_id)));

endmodule

bind tri_tile_binner binner_checker #(
    .IDX_W (IDX_W),
    .ID_W  (ID_W),
    .NTILES(NTILES)
) u_chk (.*);

// File: tb/tri_tile_binner_tb_top.sv
`timescale 1ns/1ps
module tri_tile_binner_tb_top;

    localparam int COORD_W = 12;
    localparam int ID_W    = 8;
    localparam int TX      = 20;
    localparam int NV      = 7;

    // x0 y0 x1 y1 x2 y2 id | col_lo col_hi row_lo row_hi off
    localparam int VEC [NV][12] = '{
        '{  10,  10,  20,   5,  31,  31, 1,   0,  0,  0,  0, 0 },
        '{  30,  40,  70,  50,  40, 100, 2,   0,  2,  1,  3, 0 },
        '{ -50, -20,  40,  10,   0,  70, 3,   0,  1,  0,  2, 0 },
        '{ 600, 450, 700, 470, 650, 600, 4,  18, 19, 14, 14, 0 },
        '{ 700,  10, 800,  20, 650,  30, 5,   0,  0,  0,  0, 1 },
        '{ -10, -10,  -1,  -5,  -3,  -1, 6,   0,  0,  0,  0, 1 },
        '{  64,  64,  64,  64,  64,  64, 7,   2,  2,  2,  2, 0 }
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [COORD_W-1:0] in_x0 = '0, in_y0 = '0, in_x1 = '0;
    logic signed [COORD_W-1:0] in_y1 = '0, in_x2 = '0, in_y2 = '0;
    logic [ID_W-1:0] in_id = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [8:0] out_tile;
    logic [ID_W-1:0] out_id;
    logic out_last;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tri_tile_binner #(
        .SCR_W(640), .SCR_H(480), .COORD_W(COORD_W), .ID_W(ID_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .in_x2(in_x2), .in_y2(in_y2), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_tile(out_tile),
        .out_id(out_id), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic present(input int i);
        in_x0 = COORD_W'(VEC[i][0]); in_y0 = COORD_W'(VEC[i][1]);
        in_x1 = COORD_W'(VEC[i][2]); in_y1 = COORD_W'(VEC[i][3]);
        in_x2 = COORD_W'(VEC[i][4]); in_y2 = COORD_W'(VEC[i][5]);
        in_id = ID_W'(VEC[i][6]);
        in_valid = 1'b1;
    endtask

    // Drive one triangle, then walk the expected row-major records.
    task automatic run_vec(input int i, input bit stall);
        int phase;
        bit rdy;
        bit first;
        phase = 0;
        first = 1;
        @(negedge clk);
        check(in_ready == 1'b1, "R2 ready before accept", int'(in_ready), 1);
        present(i);
        @(negedge clk);
        in_valid = 1'b0;
        if (VEC[i][11] == 1) begin
            check(out_valid == 1'b0, "R8 no record off screen", int'(out_valid), 0);
            check(in_ready == 1'b1, "R8 ready after drop", int'(in_ready), 1);
        end else begin
            for (int r = VEC[i][9]; r <= VEC[i][10]; r++) begin
                for (int c = VEC[i][7]; c <= VEC[i][8]; c++) begin
                    do begin
                        rdy = stall ? phase[0] : 1'b1;
                        phase++;
                        out_ready = rdy;
                        check(out_valid == 1'b1, first ? "R11 first record next cycle" : "R5 record present",
                              int'(out_valid), 1);
                        check(int'(out_tile) == r * TX + c,
                              stall ? "R9 R5 R6 R3 R4 tile" : "R5 R6 R3 R4 tile",
                              int'(out_tile), r * TX + c);
                        check(out_id == ID_W'(VEC[i][6]), "R10 id", int'(out_id), VEC[i][6]);
                        check(out_last == (r == VEC[i][10] && c == VEC[i][8]), "R7 last flag",
                              int'(out_last), int'(r == VEC[i][10] && c == VEC[i][8]));
                        check(in_ready == 1'b0, "R2 closed during walk", int'(in_ready), 0);
                        first = 0;
                        @(negedge clk);
                    end while (!rdy);
                end
            end
            out_ready = 1'b0;
            check(out_valid == 1'b0, "R7 walk ended", int'(out_valid), 0);
            check(in_ready == 1'b1, "R7 input reopened", int'(in_ready), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // table walk, no backpressure
        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // backpressure on row wraps and final records
        run_vec(1, 1'b1);
        run_vec(2, 1'b1);
        run_vec(3, 1'b1);

        // reset in the middle of a walk
        @(negedge clk);
        present(1);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b1, "R5 mid walk", int'(out_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset mid walk", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 reset reopens", int'(in_ready), 1);
        rst_n = 1'b1;
        out_ready = 1'b0;
        run_vec(6, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule